// File: doc/BRIEF.md
# Buffered SPI Transaction Sequencer

This block sits between a host and an SPI byte shifter and runs complete transactions out of a local write buffer. The host fills the write buffer byte by byte, then issues one command. The block asserts the chosen active-low chip selects, hands each buffered byte to the shifter in turn, and appends every reply byte to a read buffer of the same depth. It then releases the selects and can clear the write buffer afterwards. A transmit-only command runs the same exchange without touching any chip select. Two further commands assert or release selects on their own, so the host can build longer framed sequences.

Each chip-select command uses either a per-command 8-bit mask or, when none is given, a stored selection mask. A per-channel configured flag gates every output, so a channel that is not configured stays high. Purge commands zero a buffer's element count. Two auto-purge options clear the read buffer before an exchange and the write buffer after it. A read request returns either the newest or the oldest captured byte, or flags that the read buffer is empty.

Top module: `spi_txn_seq`

## Requirements
- R1: After reset every `cs_n` bit is 1, `busy` is 0, both counts are 0, both overflow flags are 0 and the stored selection mask is 0xFF.
- R2: A select-and-transfer command (`cmd_op`=0) drives the selected `cs_n` bits low on the accept edge. It keeps them steady while it issues every write-buffer byte in buffer order. It drives them high on the edge where `busy` falls. `busy` is 1 from the accept edge until that release.
- R3: Each reply byte taken with `sh_done` is appended to the read buffer, so `rd_count` rises by one per exchanged byte.
- R4: The chip-select mask is `cmd_mask` when `cmd_mask_en` is 1 and the stored mask otherwise. The stored mask is written through `sel_mask_we`. A set command (`cmd_op`=2) drives low exactly the channels in mask AND `chan_cfg` and leaves the other active channels as they were.
- R5: A release command (`cmd_op`=3) drives high only the channels in its mask. Every other active channel stays low.
- R6: A transmit-only command (`cmd_op`=1) exchanges the whole write buffer and leaves `cs_n` unchanged throughout.
- R7: Purge commands set a count to zero: `cmd_op`=4 for the write buffer, 5 for the read buffer, 6 for both. The other buffer's count is left unchanged.
- R8: With `auto_purge_rd`=1 the read buffer is emptied on acceptance of a transfer command. With `auto_purge_wr`=1 the write buffer is emptied at release. With `auto_purge_wr`=0, repeating the command sends the same bytes again.
- R9: A read request (`rd_req`) gives `rd_valid` one cycle later. With `rd_order`=0 it returns the last captured byte and with `rd_order`=1 the first. When the read buffer is empty it sets `rd_empty` and returns 0.
- R10: An append to a full write buffer is dropped and sets sticky `wr_ovf`. A capture into a full read buffer is dropped and sets sticky `rd_ovf`. Counts never exceed DEPTH.
- R11: While `busy` is 1, commands and appends are ignored.
- R12: A channel with its `chan_cfg` bit at 0 never drives its `cs_n` bit low.
- R13: `sh_start` is a one-cycle pulse given only while busy. Exactly one pulse is given per write-buffer byte, and the next one waits for `sh_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (0 select+transfer, 1 transfer only, 2 set, 3 release, 4/5/6 purge write/read/both, 7 none) |
| cmd_mask_en | input | 1 | Use cmd_mask instead of the stored mask |
| cmd_mask | input | NCS | Per-command chip-select mask |
| sel_mask_we | input | 1 | Write the stored selection mask |
| sel_mask_wdata | input | NCS | New stored selection mask |
| chan_cfg | input | NCS | Per-channel configured flags |
| auto_purge_rd | input | 1 | Empty the read buffer before a transfer |
| auto_purge_wr | input | 1 | Empty the write buffer after a transfer |
| rd_order | input | 1 | 0 returns the newest byte, 1 the oldest |
| app_valid | input | 1 | Append strobe |
| app_data | input | 8 | Byte to append |
| rd_req | input | 1 | Read request |
| rd_valid | output | 1 | Read answer valid |
| rd_data | output | 8 | Read answer byte |
| rd_empty | output | 1 | Read buffer was empty |
| sh_start | output | 1 | Start one byte exchange |
| sh_tx | output | 8 | Byte to shift out |
| sh_done | input | 1 | Exchange finished |
| sh_rx | input | 8 | Byte shifted in |
| cs_n | output | NCS | Active-low chip selects |
| busy | output | 1 | Transaction in progress |
| wr_count | output | CW | Write-buffer element count |
| rd_count | output | CW | Read-buffer element count |
| wr_ovf | output | 1 | Sticky write-buffer overflow |
| rd_ovf | output | 1 | Sticky read-buffer overflow |

## Verification
The properties assume that the shifter raises `sh_done` only after a `sh_start` and for a single cycle, with no second pulse before the next start. They also assume that reset is held across several clock edges, so that `$past` never reaches back to an unknown value. The bench's shifter model waits two cycles after each start and then pulses `sh_done` once. Reset is held for five edges. The bench drives commands and appends only at falling edges, and it issues mid-transfer commands only to test that they are ignored.

// File: rtl/spi_seq_pkg.sv
// Shared types for the buffered SPI transaction sequencer.
// Assumes: command codes are fixed by the host interface and decoded here only.
package spi_seq_pkg;

    typedef enum logic [2:0] {
        OP_XFER_SEL  = 3'd0,
        OP_XFER_RAW  = 3'd1,
        OP_SEL_SET   = 3'd2,
        OP_SEL_REL   = 3'd3,
        OP_PURGE_W   = 3'd4,
        OP_PURGE_R   = 3'd5,
        OP_PURGE_ALL = 3'd6,
        OP_NONE      = 3'd7
    } seq_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_WAIT   = 2'd2,
        ST_FINISH = 2'd3
    } seq_state_e;

endpackage

// File: rtl/spi_seq_buf.sv
// Append-only byte store with an element count and a sticky overflow flag.
// Assumes: clr and push are not requested in the same cycle; clr wins if they are.
// Clearing zeroes only the count; stored bytes stay in place.
module spi_seq_buf #(
    parameter int DEPTH = 60,
    parameter int W     = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic [CW-1:0] rd_idx,
    output logic [W-1:0]  rd_data,
    output logic [CW-1:0] count,
    output logic          ovf
);

    logic [W-1:0] mem [DEPTH];
    logic         has_room;

    assign has_room = (int'(count) < DEPTH);

    // Count and overflow bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            ovf   <= 1'b0;
        end else if (clr) begin
            count <= '0;
        end else if (push) begin
            if (has_room) count <= count + CW'(1);
            else          ovf   <= 1'b1;
        end
    end

    // Data storage, not reset
    always_ff @(posedge clk) begin
        if (rst_n && !clr && push && has_room)
            mem[count[IW-1:0]] <= push_data;
    end

    // Indexed read with range guard
    always_comb begin
        if (int'(rd_idx) < DEPTH) rd_data = mem[rd_idx[IW-1:0]];
        else                      rd_data = '0;
    end

endmodule

// File: rtl/spi_seq_cs.sv
// Chip-select state: one active flag per channel, set and cleared by masks.
// Assumes: a channel is driven low only if both active and configured.
module spi_seq_cs #(
    parameter int NCS = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           set_en,
    input  logic [NCS-1:0] set_mask,
    input  logic           rel_en,
    input  logic [NCS-1:0] rel_mask,
    input  logic [NCS-1:0] chan_cfg,
    output logic [NCS-1:0] cs_n
);

    logic [NCS-1:0] active;
    logic [NCS-1:0] add_bits;
    logic [NCS-1:0] drop_bits;

    assign add_bits  = set_en ? (set_mask & chan_cfg) : '0;
    assign drop_bits = rel_en ? rel_mask : '0;

    // Active-channel flags
    always_ff @(posedge clk) begin
        if (!rst_n) active <= '0;
        else        active <= (active | add_bits) & ~drop_bits;
    end

    // Per-channel output gating
    for (genvar g = 0; g < NCS; g++) begin : g_pin
        assign cs_n[g] = ~(active[g] & chan_cfg[g]);
    end

endmodule

// File: rtl/spi_seq_ctrl.sv
// Command decoder and transfer sequencer.
// Accepts one command per cycle while idle; runs issue/wait loops over the write
// buffer, then releases selects and optionally purges the write buffer.
// Assumes: the shifter answers each sh_start with exactly one sh_done pulse.
module spi_seq_ctrl
    import spi_seq_pkg::*;
#(
    parameter int NCS = 8,
    parameter int CW  = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid,
    input  logic [2:0]     cmd_op,
    input  logic           cmd_mask_en,
    input  logic [NCS-1:0] cmd_mask,
    input  logic           sel_mask_we,
    input  logic [NCS-1:0] sel_mask_wdata,
    input  logic           auto_purge_rd,
    input  logic           auto_purge_wr,
    input  logic [CW-1:0]  wr_count,
    input  logic [7:0]     wbuf_data,
    input  logic           sh_done,
    output logic           sh_start,
    output logic [7:0]     sh_tx,
    output logic [CW-1:0]  wr_idx,
    output logic           rbuf_push,
    output logic           rbuf_clr,
    output logic           wbuf_clr,
    output logic           cs_set_en,
    output logic [NCS-1:0] cs_set_mask,
    output logic           cs_rel_en,
    output logic [NCS-1:0] cs_rel_mask,
    output logic           busy
);

    seq_state_e     state;
    seq_op_e        op;
    logic [CW-1:0]  idx;
    logic [NCS-1:0] sel_mask;
    logic [NCS-1:0] lat_mask;
    logic           with_sel;
    logic [NCS-1:0] eff_mask;
    logic           accept;
    logic           is_xfer;
    logic           more;

    assign op       = seq_op_e'(cmd_op);
    assign eff_mask = cmd_mask_en ? cmd_mask : sel_mask;
    assign accept   = cmd_valid && (state == ST_IDLE);
    assign is_xfer  = (op == OP_XFER_SEL) || (op == OP_XFER_RAW);
    assign more     = (idx < wr_count);
    assign busy     = (state != ST_IDLE);
    assign wr_idx   = idx;
    assign sh_tx    = wbuf_data;

    // Per-cycle strobes toward buffers, select logic and shifter
    always_comb begin
        sh_start    = (state == ST_ISSUE) && more;
        rbuf_push   = (state == ST_WAIT) && sh_done;
        cs_set_en   = accept && ((op == OP_XFER_SEL) || (op == OP_SEL_SET));
        cs_set_mask = eff_mask;
        cs_rel_en   = (accept && (op == OP_SEL_REL)) || ((state == ST_FINISH) && with_sel);
        cs_rel_mask = (state == ST_FINISH) ? lat_mask : eff_mask;
        rbuf_clr    = accept && ((op == OP_PURGE_R) || (op == OP_PURGE_ALL) ||
                                 (is_xfer && auto_purge_rd));
        wbuf_clr    = (accept && ((op == OP_PURGE_W) || (op == OP_PURGE_ALL))) ||
                      ((state == ST_FINISH) && auto_purge_wr);
    end

    // Stored selection mask
    always_ff @(posedge clk) begin
        if (!rst_n)           sel_mask <= '1;
        else if (sel_mask_we) sel_mask <= sel_mask_wdata;
    end

    // Transfer state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            idx      <= '0;
            lat_mask <= '0;
            with_sel <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept && is_xfer) begin
                        state    <= ST_ISSUE;
                        idx      <= '0;
                        lat_mask <= eff_mask;
                        with_sel <= (op == OP_XFER_SEL);
                    end
                end
                ST_ISSUE: state <= more ? ST_WAIT : ST_FINISH;
                ST_WAIT: begin
                    if (sh_done) begin
                        idx   <= idx + CW'(1);
                        state <= ST_ISSUE;
                    end
                end
                ST_FINISH: state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/spi_txn_seq.sv
// Top of the buffered SPI transaction sequencer.
// Holds the write and read buffers, the chip-select state and the sequencer,
// and answers host read requests one cycle after they arrive.
// Assumes: appends and commands presented while busy are to be dropped.
module spi_txn_seq #(
    parameter int DEPTH = 60,
    parameter int NCS   = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid,
    input  logic [2:0]     cmd_op,
    input  logic           cmd_mask_en,
    input  logic [NCS-1:0] cmd_mask,
    input  logic           sel_mask_we,
    input  logic [NCS-1:0] sel_mask_wdata,
    input  logic [NCS-1:0] chan_cfg,
    input  logic           auto_purge_rd,
    input  logic           auto_purge_wr,
    input  logic           rd_order,
    input  logic           app_valid,
    input  logic [7:0]     app_data,
    input  logic           rd_req,
    output logic           rd_valid,
    output logic [7:0]     rd_data,
    output logic           rd_empty,
    output logic           sh_start,
    output logic [7:0]     sh_tx,
    input  logic           sh_done,
    input  logic [7:0]     sh_rx,
    output logic [NCS-1:0] cs_n,
    output logic           busy,
    output logic [CW-1:0]  wr_count,
    output logic [CW-1:0]  rd_count,
    output logic           wr_ovf,
    output logic           rd_ovf
);

    logic [CW-1:0]  wr_idx;
    logic [7:0]     wbuf_data;
    logic [7:0]     rbuf_data;
    logic [CW-1:0]  rd_idx;
    logic           rbuf_push;
    logic           rbuf_clr;
    logic           wbuf_clr;
    logic           cs_set_en;
    logic [NCS-1:0] cs_set_mask;
    logic           cs_rel_en;
    logic [NCS-1:0] cs_rel_mask;
    logic           app_take;

    assign app_take = app_valid && !busy;
    assign rd_idx   = rd_order ? '0 : (rd_count - CW'(1));

    spi_seq_buf #(.DEPTH(DEPTH), .W(8)) u_wbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (wbuf_clr),
        .push      (app_take),
        .push_data (app_data),
        .rd_idx    (wr_idx),
        .rd_data   (wbuf_data),
        .count     (wr_count),
        .ovf       (wr_ovf)
    );

    spi_seq_buf #(.DEPTH(DEPTH), .W(8)) u_rbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (rbuf_clr),
        .push      (rbuf_push),
        .push_data (sh_rx),
        .rd_idx    (rd_idx),
        .rd_data   (rbuf_data),
        .count     (rd_count),
        .ovf       (rd_ovf)
    );

    spi_seq_cs #(.NCS(NCS)) u_cs (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (cs_set_en),
        .set_mask (cs_set_mask),
        .rel_en   (cs_rel_en),
        .rel_mask (cs_rel_mask),
        .chan_cfg (chan_cfg),
        .cs_n     (cs_n)
    );

    spi_seq_ctrl #(.NCS(NCS), .CW(CW)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_valid      (cmd_valid),
        .cmd_op         (cmd_op),
        .cmd_mask_en    (cmd_mask_en),
        .cmd_mask       (cmd_mask),
        .sel_mask_we    (sel_mask_we),
        .sel_mask_wdata (sel_mask_wdata),
        .auto_purge_rd  (auto_purge_rd),
        .auto_purge_wr  (auto_purge_wr),
        .wr_count       (wr_count),
        .wbuf_data      (wbuf_data),
        .sh_done        (sh_done),
        .sh_start       (sh_start),
        .sh_tx          (sh_tx),
        .wr_idx         (wr_idx),
        .rbuf_push      (rbuf_push),
        .rbuf_clr       (rbuf_clr),
        .wbuf_clr       (wbuf_clr),
        .cs_set_en      (cs_set_en),
        .cs_set_mask    (cs_set_mask),
        .cs_rel_en      (cs_rel_en),
        .cs_rel_mask    (cs_rel_mask),
        .busy           (busy)
    );

    // Registered answer to a host read request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            rd_empty <= 1'b0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req) begin
                rd_empty <= (rd_count == '0);
                rd_data  <= (rd_count == '0) ? 8'h00 : rbuf_data;
            end
        end
    end

endmodule

// File: rtl/spi_txn_seq_chk.sv
// Property checker for spi_txn_seq, attached by bind below.
// Assumes: sh_done is a single-cycle answer to sh_start; reset spans several edges.
module spi_txn_seq_chk #(
    parameter int DEPTH = 60,
    parameter int NCS   = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           busy,
    input logic           sh_start,
    input logic [NCS-1:0] cs_n,
    input logic [CW-1:0]  wr_count,
    input logic [CW-1:0]  rd_count,
    input logic           wr_ovf,
    input logic           rd_ovf,
    input logic           rd_valid,
    input logic           rd_empty
);

    assert_start_in_burst_R13: assert property (@(posedge clk) disable iff (!rst_n)
        sh_start |-> busy);

    assert_single_start_R13: assert property (@(posedge clk) disable iff (!rst_n)
        sh_start |=> !sh_start);

    assert_cs_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cs_n));

    assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(wr_count) <= DEPTH) && (int'(rd_count) <= DEPTH));

    assert_wr_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ovf |=> wr_ovf);

    assert_rd_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ovf |=> rd_ovf);

    assert_no_append_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(wr_count));

    assert_empty_report_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_empty) |-> ($past(rd_count) == '0));

endmodule

bind spi_txn_seq spi_txn_seq_chk #(.DEPTH(DEPTH), .NCS(NCS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .sh_start (sh_start),
    .cs_n     (cs_n),
    .wr_count (wr_count),
    .rd_count (rd_count),
    .wr_ovf   (wr_ovf),
    .rd_ovf   (rd_ovf),
    .rd_valid (rd_valid),
    .rd_empty (rd_empty)
);

// File: tb/spi_txn_seq_tb.sv
// Self-checking bench: small buffer depth, exhaustive mask sweeps, transfers of
// every length up to the depth, overflow, purge and busy-ignore cases.
module spi_txn_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;
    localparam int NCS        = 8;
    localparam int CW         = $clog2(DEPTH + 1);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cmd_valid = 1'b0;
    logic [2:0]     cmd_op = 3'd7;
    logic           cmd_mask_en = 1'b0;
    logic [NCS-1:0] cmd_mask = '0;
    logic           sel_mask_we = 1'b0;
    logic [NCS-1:0] sel_mask_wdata = '0;
    logic [NCS-1:0] chan_cfg = '1;
    logic           auto_purge_rd = 1'b1;
    logic           auto_purge_wr = 1'b0;
    logic           rd_order = 1'b0;
    logic           app_valid = 1'b0;
    logic [7:0]     app_data = '0;
    logic           rd_req = 1'b0;
    logic           rd_valid;
    logic [7:0]     rd_data;
    logic           rd_empty;
    logic           sh_start;
    logic [7:0]     sh_tx;
    logic           sh_done = 1'b0;
    logic [7:0]     sh_rx = '0;
    logic [NCS-1:0] cs_n;
    logic           busy;
    logic [CW-1:0]  wr_count;
    logic [CW-1:0]  rd_count;
    logic           wr_ovf;
    logic           rd_ovf;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 0;

    logic [7:0]     log_tx [32];
    logic [NCS-1:0] log_cs [32];
    int             log_n = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spi_txn_seq #(.DEPTH(DEPTH), .NCS(NCS)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_mask_en(cmd_mask_en), .cmd_mask(cmd_mask), .sel_mask_we(sel_mask_we),
        .sel_mask_wdata(sel_mask_wdata), .chan_cfg(chan_cfg),
        .auto_purge_rd(auto_purge_rd), .auto_purge_wr(auto_purge_wr),
        .rd_order(rd_order), .app_valid(app_valid), .app_data(app_data),
        .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data), .rd_empty(rd_empty),
        .sh_start(sh_start), .sh_tx(sh_tx), .sh_done(sh_done), .sh_rx(sh_rx),
        .cs_n(cs_n), .busy(busy), .wr_count(wr_count), .rd_count(rd_count),
        .wr_ovf(wr_ovf), .rd_ovf(rd_ovf)
    );

    // Shifter model: logs each start, answers two cycles later with tx ^ 0x3C
    initial begin
        @(negedge clk);
        forever begin
            if (sh_start) begin
                log_tx[log_n % 32] = sh_tx;
                log_cs[log_n % 32] = cs_n;
                sh_rx = sh_tx ^ 8'h3C;
                log_n++;
                @(negedge clk);
                @(negedge clk);
                sh_done = 1'b1;
                @(negedge clk);
                sh_done = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic cmd(input logic [2:0] op, input bit men, input logic [7:0] m);
        cmd_valid = 1'b1; cmd_op = op; cmd_mask_en = men; cmd_mask = m;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd7; cmd_mask_en = 1'b0;
        wait_idle();
    endtask

    task automatic append(input logic [7:0] b);
        app_valid = 1'b1; app_data = b;
        @(negedge clk);
        app_valid = 1'b0;
    endtask

    task automatic read_byte(input bit order, output logic [7:0] d, output bit e);
        rd_order = order; rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        d = rd_data; e = rd_empty;
        check(rd_valid === 1'b1, "R9 rd_valid", int'(rd_valid), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        bit e;
        logic [7:0] cfgs [3];
        cfgs[0] = 8'hFF; cfgs[1] = 8'hB7; cfgs[2] = 8'h5A;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(cs_n == 8'hFF, "R1 cs_n", int'(cs_n), 8'hFF);
        check(busy == 1'b0, "R1 busy", int'(busy), 0);
        check(wr_count == 0 && rd_count == 0, "R1 counts", int'(wr_count), 0);
        check(!wr_ovf && !rd_ovf, "R1 ovf", int'({wr_ovf, rd_ovf}), 0);
        read_byte(1'b0, d, e);
        check(e == 1'b1 && d == 8'h00, "R9 empty after reset", int'(d), 0);
        // R1: stored mask 0xFF by default
        cmd(3'd2, 1'b0, 8'h00);
        check(cs_n == 8'h00, "R1 default stored mask", int'(cs_n), 8'h00);
        cmd(3'd3, 1'b1, 8'hFF);
        check(cs_n == 8'hFF, "R5 release all", int'(cs_n), 8'hFF);

        // R4/R12: exhaustive set sweep for three channel configurations
        for (int c = 0; c < 3; c++) begin
            chan_cfg = cfgs[c];
            for (int m = 0; m < 256; m++) begin
                cmd(3'd3, 1'b1, 8'hFF);
                cmd(3'd2, 1'b1, 8'(m));
                check(cs_n == ~(8'(m) & cfgs[c]), "R4 R12 set mask", int'(cs_n),
                      int'(~(8'(m) & cfgs[c])));
            end
            // R5: exhaustive release sweep
            for (int m = 0; m < 256; m++) begin
                cmd(3'd2, 1'b1, 8'hFF);
                cmd(3'd3, 1'b1, 8'(m));
                check(cs_n == ~(cfgs[c] & ~8'(m)), "R5 release mask", int'(cs_n),
                      int'(~(cfgs[c] & ~8'(m))));
            end
        end
        chan_cfg = 8'hFF;
        cmd(3'd3, 1'b1, 8'hFF);

        // R4: set merges with channels already active
        cmd(3'd2, 1'b1, 8'h01);
        cmd(3'd2, 1'b1, 8'h10);
        check(cs_n == 8'hEE, "R4 set keeps others", int'(cs_n), 8'hEE);
        cmd(3'd3, 1'b1, 8'hFF);

        // R4: stored mask write used when no command mask
        sel_mask_we = 1'b1; sel_mask_wdata = 8'h0C;
        @(negedge clk);
        sel_mask_we = 1'b0;
        cmd(3'd2, 1'b0, 8'hFF);
        check(cs_n == 8'hF3, "R4 stored mask", int'(cs_n), 8'hF3);
        cmd(3'd3, 1'b0, 8'h00);
        check(cs_n == 8'hFF, "R5 release by stored mask", int'(cs_n), 8'hFF);

        // R2/R3/R8/R9/R13: select transfers of every length
        auto_purge_rd = 1'b0; auto_purge_wr = 1'b1;
        for (int n = 0; n <= DEPTH; n++) begin
            cmd(3'd6, 1'b0, 8'h00);
            for (int k = 0; k < n; k++) append(8'(n * 16 + k + 1));
            log_n = 0;
            cmd_valid = 1'b1; cmd_op = 3'd0; cmd_mask_en = 1'b1; cmd_mask = 8'h21;
            @(negedge clk);
            cmd_valid = 1'b0; cmd_op = 3'd7; cmd_mask_en = 1'b0;
            check(busy == 1'b1, "R2 busy after accept", int'(busy), 1);
            check(cs_n == 8'hDE, "R2 cs low on accept", int'(cs_n), 8'hDE);
            wait_idle();
            check(log_n == n, "R13 one start per byte", log_n, n);
            for (int k = 0; k < n; k++) begin
                check(log_tx[k] == 8'(n * 16 + k + 1), "R2 byte order", int'(log_tx[k]),
                      n * 16 + k + 1);
                check(log_cs[k] == 8'hDE, "R2 cs during exchange", int'(log_cs[k]), 8'hDE);
            end
            check(cs_n == 8'hFF, "R2 cs released", int'(cs_n), 8'hFF);
            check(int'(rd_count) == n, "R3 capture count", int'(rd_count), n);
            check(wr_count == 0, "R8 auto purge write", int'(wr_count), 0);
            read_byte(1'b0, d, e);
            if (n == 0) check(e == 1'b1, "R9 empty flag", int'(e), 1);
            else check(!e && d == (8'(n * 16 + n) ^ 8'h3C), "R9 newest byte", int'(d),
                       int'(8'(n * 16 + n) ^ 8'h3C));
            read_byte(1'b1, d, e);
            if (n > 0) check(!e && d == (8'(n * 16 + 1) ^ 8'h3C), "R9 oldest byte", int'(d),
                             int'(8'(n * 16 + 1) ^ 8'h3C));
        end

        // R8: resend with auto purge write off, then auto purge read
        auto_purge_wr = 1'b0;
        cmd(3'd6, 1'b0, 8'h00);
        append(8'hA1); append(8'hA2); append(8'hA3);
        log_n = 0;
        cmd(3'd0, 1'b1, 8'h01);
        cmd(3'd0, 1'b1, 8'h01);
        check(log_n == 6, "R8 resend count", log_n, 6);
        check(log_tx[3] == 8'hA1 && log_tx[5] == 8'hA3, "R8 resend bytes",
              int'(log_tx[5]), 8'hA3);
        check(wr_count == 3, "R8 write kept", int'(wr_count), 3);
        check(rd_count == 4, "R10 read capped", int'(rd_count), 4);
        check(rd_ovf == 1'b1, "R10 read overflow", int'(rd_ovf), 1);
        auto_purge_rd = 1'b1;
        cmd(3'd0, 1'b1, 8'h01);
        check(rd_count == 3, "R8 auto purge read", int'(rd_count), 3);

        // R6: transfer only leaves selects alone
        cmd(3'd2, 1'b1, 8'h05);
        log_n = 0;
        cmd(3'd1, 1'b1, 8'hFF);
        check(log_n == 3 && log_cs[0] == 8'hFA, "R6 cs during raw", int'(log_cs[0]), 8'hFA);
        check(cs_n == 8'hFA, "R6 cs after raw", int'(cs_n), 8'hFA);
        cmd(3'd3, 1'b1, 8'hFF);

        // R7: purges act on one buffer each
        cmd(3'd4, 1'b0, 8'h00);
        check(wr_count == 0 && rd_count == 3, "R7 purge write", int'(rd_count), 3);
        cmd(3'd5, 1'b0, 8'h00);
        check(rd_count == 0, "R7 purge read", int'(rd_count), 0);

        // R10: write overflow
        check(wr_ovf == 1'b0, "R10 no overflow yet", int'(wr_ovf), 0);
        for (int k = 0; k < DEPTH + 1; k++) append(8'(k + 8'h50));
        check(int'(wr_count) == DEPTH, "R10 write capped", int'(wr_count), DEPTH);
        check(wr_ovf == 1'b1, "R10 write overflow", int'(wr_ovf), 1);

        // R11: commands and appends ignored while busy
        cmd(3'd4, 1'b0, 8'h00);
        append(8'h11); append(8'h22);
        cmd_valid = 1'b1; cmd_op = 3'd0; cmd_mask_en = 1'b1; cmd_mask = 8'h01;
        @(negedge clk);
        cmd_op = 3'd2; cmd_mask = 8'h80; app_valid = 1'b1; app_data = 8'h33;
        @(negedge clk);
        cmd_op = 3'd4; app_valid = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd7; cmd_mask_en = 1'b0;
        wait_idle();
        check(wr_count == 2, "R11 append and purge ignored", int'(wr_count), 2);
        check(cs_n == 8'hFF, "R11 set ignored", int'(cs_n), 8'hFF);

        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule